// File: doc/BRIEF.md
# Two-Port Round-Robin Crossbar Switch Element

This block is a 2x2 switching element for a multistage packet network. Each of its two input ports accepts one packet at a time into a one-entry buffer. Every packet carries a 2-bit set of outputs it may leave by. Each of the two output ports presents one packet at a time from a one-entry buffer. Every cycle a fixed decision table looks at which outputs each waiting packet may use and which output buffers can take a packet. It then moves whole packets across the crossbar, one buffer forward.

Where a request pattern has exactly one best assignment, the table applies it directly. Two round-robin pointers settle the remaining cases. A spread pointer picks the output when a packet may use both outputs and both are free, so that flexible traffic alternates between them. A conflict pointer picks the winning input when both packets can reach only the same single output, so that neither input starves. A pointer moves only in a cycle in which it decided a grant.

All data ports are valid/ready. An input takes a packet on a clock edge where its valid and ready are both high. Ready is high only while that input's buffer is empty, so a packet waiting for an output holds off the next one. An output keeps its valid and data steady until its ready is seen high. Its buffer can take a new packet on the same edge that hands the old one downstream.

Top module: `sw2_xbar`

## Requirements
- R1: After reset both outputs are invalid, both inputs are ready, and both pointers favour index 0 (output 0 for spreading, input 0 for conflicts).
- R2: An input's ready is high exactly when its buffer is empty. A packet accepted at one edge is in the input buffer after that edge and can reach a free output buffer at the next edge.
- R3: Mask bit 0 permits output 0 and mask bit 1 permits output 1. A packet with a single bit set leaves only by that output. Its data is delivered unchanged.
- R4: A packet permitted on both outputs, when exactly one of them can accept this cycle, is sent to that output whatever the spread pointer says.
- R5: A lone packet permitted on both outputs, when both can accept, goes to the output named by the spread pointer. The pointer then flips. It does not move in cycles where it decided nothing.
- R6: When both inputs can reach only the same single output, the input named by the conflict pointer wins and the pointer flips. The other packet stays in its input buffer, holds that input's ready low and is arbitrated again next cycle.
- R7: When both packets are permitted on both outputs and both outputs can accept, input 0 gets the output named by the spread pointer and input 1 gets the other one. The spread pointer then flips.
- R8: When the two packets can use different single outputs, both move in the same cycle. When one can use a single output and the other can use both, the flexible packet takes the other output. No pointer is used in either case.
- R9: An output holds valid and data steady while its ready is low. An output whose packet is taken on an edge can be loaded with a new packet on that same edge.
- R10: A packet whose mask is 00 is discarded one cycle after it is accepted and never appears at an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Per-input packet valid, bit i for input i |
| in_ready | output | 2 | Per-input ready, high while that input buffer is empty |
| in_mask | input | 4 | Permitted outputs, bits [2i+1:2i] for input i |
| in_data | input | 2*DATA_W | Packet payload, slice i for input i |
| out_valid | output | 2 | Per-output packet valid |
| out_ready | input | 2 | Per-output downstream ready |
| out_data | output | 2*DATA_W | Packet payload, slice j for output j |

## Verification
Directed scenarios cover every request pattern class of the decision table. Single-bit masks from either input show plain routing. A flexible packet next to a busy output shows that buffer availability overrides the spread pointer. A lone flexible packet sent twice, after a single-output packet, shows both alternation and a pointer that holds still when unused. Same-output conflicts run twice tell whether the winner alternates. A conflict drained with ready held high shows that an output refills on the edge it empties. Two flexible packets, and mixed single/flexible pairs, show whether the table finds the unique full assignment instead of consulting a pointer. Stalled outputs, blocked inputs and an empty mask show that back-pressure holds packets in place and that empty-mask packets are discarded.

// File: rtl/sw2_pkg.sv
package sw2_pkg;
  localparam int NPORT = 2;
  localparam int MASK_W = NPORT;

  typedef logic [NPORT-1:0] portset_t;

  // Index of the set bit in a one-hot two-port set.
  function automatic logic port_of(input portset_t s);
    return s[1];
  endfunction
endpackage

// File: rtl/sw2_slot.sv
module sw2_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] d,
  output logic         full,
  output logic [W-1:0] q
);
  // Load has priority so a slot emptied on this edge can be refilled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else if (load) begin
      full <= 1'b1;
      q    <= d;
    end else if (clear) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sw2_alloc.sv
module sw2_alloc
  import sw2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  portset_t   req0,
  input  portset_t   req1,
  input  portset_t   free,
  output logic [1:0] g_vld,
  output logic [1:0] g_dst
);
  portset_t e0, e1;
  logic     sp_q, cp_q;
  logic     sp_use, cp_use;

  always_comb begin
    e0     = req0 & free;
    e1     = req1 & free;
    g_vld  = '0;
    g_dst  = '0;
    sp_use = 1'b0;
    cp_use = 1'b0;
    case ({e1 != '0, e0 != '0})
      2'b01: begin
        g_vld[0] = 1'b1;
        if (e0 == 2'b11) begin
          g_dst[0] = sp_q;
          sp_use   = 1'b1;
        end else begin
          g_dst[0] = port_of(e0);
        end
      end
      2'b10: begin
        g_vld[1] = 1'b1;
        if (e1 == 2'b11) begin
          g_dst[1] = sp_q;
          sp_use   = 1'b1;
        end else begin
          g_dst[1] = port_of(e1);
        end
      end
      2'b11: begin
        if (e0 == 2'b11 && e1 == 2'b11) begin
          g_vld    = 2'b11;
          g_dst[0] = sp_q;
          g_dst[1] = ~sp_q;
          sp_use   = 1'b1;
        end else if (e0 == 2'b11) begin
          g_vld    = 2'b11;
          g_dst[1] = port_of(e1);
          g_dst[0] = ~port_of(e1);
        end else if (e1 == 2'b11) begin
          g_vld    = 2'b11;
          g_dst[0] = port_of(e0);
          g_dst[1] = ~port_of(e0);
        end else if (e0 != e1) begin
          g_vld    = 2'b11;
          g_dst[0] = port_of(e0);
          g_dst[1] = port_of(e1);
        end else begin
          cp_use      = 1'b1;
          g_vld[cp_q] = 1'b1;
          g_dst[cp_q] = port_of(e0);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= 1'b0;
      cp_q <= 1'b0;
    end else begin
      sp_q <= sp_q ^ sp_use;
      cp_q <= cp_q ^ cp_use;
    end
  end
endmodule

// File: rtl/sw2_xbar.sv
module sw2_xbar
  import sw2_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          in_valid,
  output logic [NPORT-1:0]          in_ready,
  input  logic [NPORT*MASK_W-1:0]   in_mask,
  input  logic [NPORT*DATA_W-1:0]   in_data,
  output logic [NPORT-1:0]          out_valid,
  input  logic [NPORT-1:0]          out_ready,
  output logic [NPORT*DATA_W-1:0]   out_data
);
  localparam int SLOT_W = MASK_W + DATA_W;

  logic [NPORT-1:0]  in_full;
  logic [SLOT_W-1:0] in_q [NPORT];
  portset_t          req [NPORT];
  logic [NPORT-1:0]  drop;
  logic [DATA_W-1:0] out_q [NPORT];
  portset_t          free;
  logic [1:0]        g_vld;
  logic [1:0]        g_dst;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [MASK_W-1:0] mask_q;
    assign mask_q      = in_q[i][SLOT_W-1 -: MASK_W];
    assign in_ready[i] = ~in_full[i];
    assign drop[i]     = in_full[i] & (mask_q == '0);
    assign req[i]      = in_full[i] ? mask_q : '0;

    sw2_slot #(.W(SLOT_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (in_valid[i] & ~in_full[i]),
      .clear (g_vld[i] | drop[i]),
      .d     ({in_mask[i*MASK_W +: MASK_W], in_data[i*DATA_W +: DATA_W]}),
      .full  (in_full[i]),
      .q     (in_q[i])
    );
  end

  sw2_alloc u_alloc (
    .clk   (clk),
    .rst_n (rst_n),
    .req0  (req[0]),
    .req1  (req[1]),
    .free  (free),
    .g_vld (g_vld),
    .g_dst (g_dst)
  );

  for (genvar j = 0; j < NPORT; j++) begin : g_out
    logic              hit0, hit1;
    logic [DATA_W-1:0] xsel;
    assign hit0    = g_vld[0] && (g_dst[0] == 1'(j));
    assign hit1    = g_vld[1] && (g_dst[1] == 1'(j));
    assign xsel    = hit1 ? in_q[1][DATA_W-1:0] : in_q[0][DATA_W-1:0];
    assign free[j] = ~out_valid[j] | out_ready[j];
    assign out_data[j*DATA_W +: DATA_W] = out_q[j];

    sw2_slot #(.W(DATA_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hit0 | hit1),
      .clear (out_ready[j]),
      .d     (xsel),
      .full  (out_valid[j]),
      .q     (out_q[j])
    );
  end
endmodule

// File: rtl/sw2_xbar_chk.sv
module sw2_xbar_chk #(
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            in_valid,
  input logic [1:0]            in_ready,
  input logic [1:0]            out_valid,
  input logic [1:0]            out_ready,
  input logic [2*DATA_W-1:0]   out_data,
  input logic [1:0]            g_vld,
  input logic [1:0]            g_dst
);
  for (genvar k = 0; k < 2; k++) begin : g_k
    // R9: a stalled output keeps its packet
    a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[k] && !out_ready[k]) |=>
        (out_valid[k] && $stable(out_data[k*DATA_W +: DATA_W])));

    // R2: an accepted packet occupies the input buffer
    a_r2_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[k] && in_ready[k]) |=> !in_ready[k]);

    // R4: grants only go to outputs that can accept this cycle
    a_r4_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
      g_vld[k] |-> (!out_valid[g_dst[k]] || out_ready[g_dst[k]]));
  end

  // R8: two grants in one cycle never share an output
  a_r8_distinct_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (g_vld == 2'b11) |-> (g_dst[0] != g_dst[1]));
endmodule

bind sw2_xbar sw2_xbar_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .g_vld     (g_vld),
  .g_dst     (g_dst)
);

// File: tb/sw2_xbar_bench.sv
module sw2_xbar_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    in_valid = '0;
  logic [1:0]    in_ready;
  logic [3:0]    in_mask = '0;
  logic [2*DW-1:0] in_data = '0;
  logic [1:0]    out_valid;
  logic [1:0]    out_ready = '0;
  logic [2*DW-1:0] out_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sw2_xbar #(.DATA_W(DW)) u_sw2_xbar (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_mask(in_mask), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] od(input int j);
    return out_data[j*DW +: DW];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = '0; in_mask = '0; in_data = '0; out_ready = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input int i, input logic [1:0] m, input logic [DW-1:0] d);
    in_valid[i] = 1'b1;
    in_mask[2*i +: 2] = m;
    in_data[DW*i +: DW] = d;
  endtask

  task automatic step();
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic drain(input logic [1:0] which);
    out_ready = which;
    step();
    out_ready = '0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "out_valid after reset", out_valid, 2'b00);
    check("R1", "in_ready after reset", in_ready, 2'b11);
  endtask

  task automatic t_single();
    do_reset();
    put(0, 2'b01, 8'hA1); step();
    check("R2", "input 0 busy after accept", in_ready, 2'b10);
    check("R2", "nothing out yet", out_valid, 2'b00);
    step();
    check("R3", "mask 01 to output 0", out_valid, 2'b01);
    check("R3", "output 0 data", od(0), 8'hA1);
    check("R2", "input freed after move", in_ready, 2'b11);
    step(); step();
    check("R9", "stalled output still valid", out_valid, 2'b01);
    check("R9", "stalled output data", od(0), 8'hA1);
    drain(2'b01);
    check("R9", "output empties on ready", out_valid, 2'b00);
    put(1, 2'b10, 8'hB2); step(); step();
    check("R3", "mask 10 from input 1 to output 1", out_valid, 2'b10);
    check("R3", "output 1 data", od(1), 8'hB2);
  endtask

  task automatic t_spread();
    do_reset();
    put(0, 2'b10, 8'hC1); step(); step();
    check("R3", "single packet to output 1", out_valid, 2'b10);
    drain(2'b11);
    put(0, 2'b11, 8'hC2); step(); step();
    check("R5", "first flexible to output 0 (pointer unmoved)", out_valid, 2'b01);
    check("R5", "first flexible data", od(0), 8'hC2);
    drain(2'b11);
    put(0, 2'b11, 8'hC3); step(); step();
    check("R5", "second flexible alternates to output 1", out_valid, 2'b10);
    check("R5", "second flexible data", od(1), 8'hC3);
  endtask

  task automatic t_free();
    do_reset();
    put(0, 2'b01, 8'hD1); step(); step();
    put(1, 2'b11, 8'hD2); step(); step();
    check("R4", "flexible takes the free output", out_valid, 2'b11);
    check("R4", "output 1 data", od(1), 8'hD2);
    check("R4", "output 0 kept", od(0), 8'hD1);
  endtask

  task automatic t_conflict();
    do_reset();
    put(0, 2'b01, 8'hE0); put(1, 2'b01, 8'hE1); step(); step();
    check("R6", "first conflict winner input 0", od(0), 8'hE0);
    check("R6", "loser input 1 held", in_ready, 2'b01);
    step();
    check("R6", "loser still held while output busy", in_ready, 2'b01);
    drain(2'b01);
    check("R9", "output refilled on emptying edge", out_valid, 2'b01);
    check("R9", "refilled data", od(0), 8'hE1);
    check("R6", "inputs free after refill", in_ready, 2'b11);
    drain(2'b01);
    check("R9", "output empty", out_valid, 2'b00);
    put(0, 2'b01, 8'hE2); put(1, 2'b01, 8'hE3); step(); step();
    check("R6", "second conflict winner input 1", od(0), 8'hE3);
    check("R6", "loser input 0 held", in_ready, 2'b10);
  endtask

  task automatic t_both_flex();
    do_reset();
    put(0, 2'b11, 8'hF0); put(1, 2'b11, 8'hF1); step(); step();
    check("R7", "both outputs loaded", out_valid, 2'b11);
    check("R7", "input 0 to output 0", od(0), 8'hF0);
    check("R7", "input 1 to output 1", od(1), 8'hF1);
    drain(2'b11);
    put(0, 2'b11, 8'h60); put(1, 2'b11, 8'h61); step(); step();
    check("R7", "input 0 to output 1 after flip", od(1), 8'h60);
    check("R7", "input 1 to output 0 after flip", od(0), 8'h61);
  endtask

  task automatic t_mixed();
    do_reset();
    put(0, 2'b10, 8'h70); put(1, 2'b01, 8'h71); step(); step();
    check("R8", "disjoint singles both move", out_valid, 2'b11);
    check("R8", "output 1 from input 0", od(1), 8'h70);
    check("R8", "output 0 from input 1", od(0), 8'h71);
    drain(2'b11);
    put(0, 2'b11, 8'h72); put(1, 2'b01, 8'h73); step(); step();
    check("R8", "flexible takes other output", od(1), 8'h72);
    check("R8", "single keeps its output", od(0), 8'h73);
  endtask

  task automatic t_block();
    do_reset();
    put(0, 2'b01, 8'h80); step(); step();
    put(0, 2'b01, 8'h81); step(); step(); step();
    check("R6", "blocked packet holds input", in_ready, 2'b10);
    check("R9", "head packet unchanged", od(0), 8'h80);
    drain(2'b01);
    check("R9", "blocked packet moves on drain", od(0), 8'h81);
    check("R2", "input ready again", in_ready, 2'b11);
  endtask

  task automatic t_drop();
    do_reset();
    put(0, 2'b00, 8'h90); step();
    check("R10", "empty mask packet accepted", in_ready, 2'b10);
    step();
    check("R10", "empty mask packet discarded", in_ready, 2'b11);
    check("R10", "nothing delivered", out_valid, 2'b00);
    step();
    check("R10", "still nothing delivered", out_valid, 2'b00);
  endtask

  initial begin
    t_reset();
    t_single();
    t_spread();
    t_free();
    t_conflict();
    t_both_flex();
    t_mixed();
    t_block();
    t_drop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule